// File: doc/BRIEF.md
# Fronthaul Arrival Window Classifier

This block sorts received fronthaul messages by arrival time. A packet parser upstream gives one strobe for each message, with the message's eCPRI type, its direction, its DU port and its measured arrival delay in nanoseconds. The block compares the delay with a minimum and maximum bound pair and classifies the message as early, on time or late. The bound pair depends on the message: user-plane messages use one pair, control-plane uplink messages a second pair and control-plane downlink messages a third. The result drives a bank of statistics counters and a one-cycle window-error pulse.

User-plane messages go to three aggregate counters. Control-plane messages go to a separate early/on-time/late set for each direction and each DU port. A total counter records every user-plane or control-plane message, whether or not window checking is on. Software reads each counter as two words. Reading the lower word captures the upper word in a shadow register, so a later upper-word read belongs to the same snapshot. A synchronous clear input zeroes every counter in one cycle.

Top module: `fh_arrival_classifier`

## Requirements
- R1: After synchronous reset, every counter reads zero and `win_err` is low.
- R2: The bounds are inclusive. A delay below the selected minimum is early, a delay above the selected maximum is late, and any other delay, including a delay equal to either bound, is on time. Class codes are early=0, on time=1, late=2.
- R3: A message with type 0 is user plane. It is classified with `up_min`/`up_max` for either direction and counts in counter 1 + class (1 early, 2 on time, 3 late).
- R4: A message with type 2 is control plane. It uses `cpul_min`/`cpul_max` when `msg_dir`=0 (uplink) and `cpdl_min`/`cpdl_max` when `msg_dir`=1 (downlink). It counts in counter 4 + (dir*3 + class)*NUM_PORTS + port.
- R5: Counter 0 (total) increments once for each type 0 or type 2 message, whether or not the window is enabled. A message of any other type changes no counter and raises no pulse.
- R6: When `rd_en` is high with `rd_hi`=0, `rd_data` shows the lower WORD_W bits of counter `rd_addr` on the following cycle. A counter is CNT_W = 2*WORD_W bits wide and wraps to zero.
- R7: When `win_en` is low, a message updates only the total counter and raises no `win_err`.
- R8: A lower-word read stores the counter's upper word. A later read with `rd_hi`=1 returns that stored word, even if the counter has changed since.
- R9: While `clr` is high, every counter is zero at the next edge, even if a message arrives in the same cycle.
- R10: When `win_en` is high, an early or late type 0/2 message sets `win_err` high for the single following cycle. An on-time message leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all counters |
| win_en | input | 1 | Receive window checking enable |
| up_min | input | DELAY_W | User-plane minimum delay (ns) |
| up_max | input | DELAY_W | User-plane maximum delay (ns) |
| cpul_min | input | DELAY_W | Control-plane uplink minimum (ns) |
| cpul_max | input | DELAY_W | Control-plane uplink maximum (ns) |
| cpdl_min | input | DELAY_W | Control-plane downlink minimum (ns) |
| cpdl_max | input | DELAY_W | Control-plane downlink maximum (ns) |
| msg_valid | input | 1 | One message this cycle |
| msg_type | input | 8 | eCPRI message type |
| msg_dir | input | 1 | 0 uplink, 1 downlink |
| msg_port | input | $clog2(NUM_PORTS) | DU port identifier |
| msg_delay | input | DELAY_W | Measured arrival delay (ns) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | $clog2(4+6*NUM_PORTS) | Counter index |
| rd_hi | input | 1 | 1 selects the stored upper word |
| rd_data | output | WORD_W | Read word, registered |
| win_err | output | 1 | Window-error pulse |

## Verification
The bench keeps the default 16 ports and 32-bit delays but sets WORD_W=4. Each counter is then only 8 bits wide, so the lower word wraps after 16 messages and the upper word starts to count. This lets a short run check that an upper-word read returns the snapshot taken at the lower-word read, even after the counter has moved on. After the vector walk, the bench reads all 100 counter slots, so a message sent to the wrong port, direction or class shows up as a mismatch.

// File: rtl/fhw_pkg.sv
package fhw_pkg;

    typedef enum logic [1:0] {
        CLS_EARLY = 2'd0,
        CLS_ON    = 2'd1,
        CLS_LATE  = 2'd2
    } win_cls_e;

    localparam logic [7:0] TYPE_UPLANE = 8'd0;
    localparam logic [7:0] TYPE_CPLANE = 8'd2;

    typedef struct packed {
        logic     up;
        logic     cp;
        logic     dir;
        win_cls_e cls;
    } msg_tag_t;

    function automatic int num_counters(int np);
        return 4 + 6 * np;
    endfunction

    function automatic int slot_of(int np, logic cp, logic dir, win_cls_e c, int port);
        if (!cp) return 1 + int'(c);
        return 4 + (int'(dir) * 3 + int'(c)) * np + port;
    endfunction

endpackage

// File: rtl/fhw_window_check.sv
module fhw_window_check
    import fhw_pkg::*;
#(
    parameter int DELAY_W = 32
) (
    input  logic [DELAY_W-1:0] delay,
    input  logic [DELAY_W-1:0] lo,
    input  logic [DELAY_W-1:0] hi,
    output win_cls_e           cls
);
    always_comb begin
        if (delay < lo)      cls = CLS_EARLY;
        else if (delay > hi) cls = CLS_LATE;
        else                 cls = CLS_ON;
    end
endmodule

// File: rtl/fhw_counter_bank.sv
module fhw_counter_bank #(
    parameter int N     = 100,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [N-1:0]     inc,
    output logic [CNT_W-1:0] cnt_q [N]
);
    for (genvar i = 0; i < N; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clr)  cnt_q[i] <= '0;
            else if (inc[i]) cnt_q[i] <= cnt_q[i] + 1'b1;
        end
    end
endmodule

// File: rtl/fhw_read_port.sv
module fhw_read_port #(
    parameter int N      = 100,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*WORD_W-1:0] cnt_q [N],
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_hi,
    output logic [WORD_W-1:0]   rd_data,
    output logic [WORD_W-1:0]   shadow
);
    logic [2*WORD_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++)
            if (rd_addr == ADDR_W'(i)) sel = cnt_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            shadow  <= '0;
        end else if (rd_en) begin
            if (rd_hi) begin
                rd_data <= shadow;
            end else begin
                rd_data <= sel[WORD_W-1:0];
                shadow  <= sel[2*WORD_W-1:WORD_W];
            end
        end
    end
endmodule

// File: rtl/fh_arrival_classifier.sv
module fh_arrival_classifier
    import fhw_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int DELAY_W   = 32,
    parameter int WORD_W    = 32
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  clr,
    input  logic                                  win_en,
    input  logic [DELAY_W-1:0]                    up_min,
    input  logic [DELAY_W-1:0]                    up_max,
    input  logic [DELAY_W-1:0]                    cpul_min,
    input  logic [DELAY_W-1:0]                    cpul_max,
    input  logic [DELAY_W-1:0]                    cpdl_min,
    input  logic [DELAY_W-1:0]                    cpdl_max,
    input  logic                                  msg_valid,
    input  logic [7:0]                            msg_type,
    input  logic                                  msg_dir,
    input  logic [$clog2(NUM_PORTS)-1:0]          msg_port,
    input  logic [DELAY_W-1:0]                    msg_delay,
    input  logic                                  rd_en,
    input  logic [$clog2(4+6*NUM_PORTS)-1:0]      rd_addr,
    input  logic                                  rd_hi,
    output logic [WORD_W-1:0]                     rd_data,
    output logic                                  win_err
);
    localparam int N_CNT  = num_counters(NUM_PORTS);
    localparam int ADDR_W = $clog2(N_CNT);
    localparam int CNT_W  = 2 * WORD_W;

    msg_tag_t            tag;
    win_cls_e            cls;
    logic [DELAY_W-1:0]  lo_sel, hi_sel;
    logic [ADDR_W-1:0]   slot;
    logic [N_CNT-1:0]    inc;
    logic [CNT_W-1:0]    cnt_all [N_CNT];
    logic [CNT_W-1:0]    total_q;
    logic [WORD_W-1:0]   shadow;

    // message decode and bound selection
    always_comb begin
        tag.up  = msg_valid && (msg_type == TYPE_UPLANE);
        tag.cp  = msg_valid && (msg_type == TYPE_CPLANE);
        tag.dir = msg_dir;
        tag.cls = cls;
        if (!tag.cp) begin
            lo_sel = up_min;
            hi_sel = up_max;
        end else if (msg_dir) begin
            lo_sel = cpdl_min;
            hi_sel = cpdl_max;
        end else begin
            lo_sel = cpul_min;
            hi_sel = cpul_max;
        end
    end

    fhw_window_check #(.DELAY_W(DELAY_W)) u_check (
        .delay (msg_delay),
        .lo    (lo_sel),
        .hi    (hi_sel),
        .cls   (cls)
    );

    always_comb begin
        slot = ADDR_W'(slot_of(NUM_PORTS, tag.cp, tag.dir, tag.cls, int'(msg_port)));
        inc  = '0;
        if (tag.up || tag.cp) begin
            inc[0] = 1'b1;
            if (win_en) inc[slot] = 1'b1;
        end
    end

    fhw_counter_bank #(.N(N_CNT), .CNT_W(CNT_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .inc   (inc),
        .cnt_q (cnt_all)
    );

    assign total_q = cnt_all[0];

    fhw_read_port #(.N(N_CNT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .cnt_q   (cnt_all),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_hi   (rd_hi),
        .rd_data (rd_data),
        .shadow  (shadow)
    );

    always_ff @(posedge clk) begin
        if (rst) win_err <= 1'b0;
        else     win_err <= win_en && (tag.up || tag.cp) && (tag.cls != CLS_ON);
    end
endmodule

// File: rtl/fhw_arrival_chk.sv
module fhw_arrival_chk #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              win_en,
    input logic              msg_valid,
    input logic [7:0]        msg_type,
    input logic              win_err,
    input logic              rd_en,
    input logic              rd_hi,
    input logic [WORD_W-1:0] rd_data,
    input logic [WORD_W-1:0] shadow,
    input logic [CNT_W-1:0]  total
);
    logic known;
    assign known = msg_valid && (msg_type == 8'd0 || msg_type == 8'd2);

    p_err_gated_r10: assert property (@(posedge clk) disable iff (rst)
        win_err |-> $past(win_en && known));

    p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (total == '0));

    p_total_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && known) |=> (total == CNT_W'($past(total) + 1'b1)));

    p_total_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !known) |=> (total == $past(total)));

    p_hi_from_shadow_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_hi) |=> (rd_data == $past(shadow)));

    p_shadow_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || rd_hi) |=> $stable(shadow));
endmodule

bind fh_arrival_classifier fhw_arrival_chk #(
    .CNT_W  (2 * WORD_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .win_en    (win_en),
    .msg_valid (msg_valid),
    .msg_type  (msg_type),
    .win_err   (win_err),
    .rd_en     (rd_en),
    .rd_hi     (rd_hi),
    .rd_data   (rd_data),
    .shadow    (shadow),
    .total     (total_q)
);

// File: tb/fh_arrival_classifier_tb.sv
module fh_arrival_classifier_tb;
    localparam int NP = 16;
    localparam int WW = 4;
    localparam int NC = 4 + 6 * NP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        win_en = 1'b1;
    logic [31:0] up_min = 32'd100, up_max = 32'd200;
    logic [31:0] cpul_min = 32'd50, cpul_max = 32'd60;
    logic [31:0] cpdl_min = 32'd1000, cpdl_max = 32'd5000;
    logic        msg_valid = 1'b0;
    logic [7:0]  msg_type = 8'd0;
    logic        msg_dir = 1'b0;
    logic [3:0]  msg_port = 4'd0;
    logic [31:0] msg_delay = 32'd0;
    logic        rd_en = 1'b0;
    logic [6:0]  rd_addr = 7'd0;
    logic        rd_hi = 1'b0;
    logic [WW-1:0] rd_data;
    logic        win_err;

    int n_run = 0;
    int n_fail = 0;
    int exp_cnt [NC];

    always #2 clk = ~clk;

    fh_arrival_classifier #(.NUM_PORTS(NP), .DELAY_W(32), .WORD_W(WW)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .win_en(win_en),
        .up_min(up_min), .up_max(up_max), .cpul_min(cpul_min), .cpul_max(cpul_max),
        .cpdl_min(cpdl_min), .cpdl_max(cpdl_max),
        .msg_valid(msg_valid), .msg_type(msg_type), .msg_dir(msg_dir),
        .msg_port(msg_port), .msg_delay(msg_delay),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_hi(rd_hi),
        .rd_data(rd_data), .win_err(win_err)
    );

    typedef struct packed {
        logic [7:0]  typ;
        logic        dir;
        logic [3:0]  port;
        logic [31:0] dly;
        logic [7:0]  idx;   // 8'hFF: no class counter
        logic        err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{8'd0, 1'b0, 4'd0,  32'd150,  8'd2,   1'b0},  // R3 on time
        '{8'd0, 1'b0, 4'd0,  32'd99,   8'd1,   1'b1},  // R2 early
        '{8'd0, 1'b0, 4'd0,  32'd100,  8'd2,   1'b0},  // R2 min inclusive
        '{8'd0, 1'b0, 4'd0,  32'd200,  8'd2,   1'b0},  // R2 max inclusive
        '{8'd0, 1'b0, 4'd0,  32'd201,  8'd3,   1'b1},  // R2 late
        '{8'd0, 1'b1, 4'd0,  32'd250,  8'd3,   1'b1},  // R3 direction ignored
        '{8'd2, 1'b0, 4'd3,  32'd55,   8'd23,  1'b0},  // R4 ul on port 3
        '{8'd2, 1'b0, 4'd15, 32'd49,   8'd19,  1'b1},  // R4 ul early port 15
        '{8'd2, 1'b0, 4'd15, 32'd61,   8'd51,  1'b1},  // R4 ul late port 15
        '{8'd2, 1'b1, 4'd0,  32'd999,  8'd52,  1'b1},  // R4 dl early port 0
        '{8'd2, 1'b1, 4'd7,  32'd5000, 8'd75,  1'b0},  // R4 dl on port 7
        '{8'd2, 1'b1, 4'd15, 32'd5001, 8'd99,  1'b1},  // R4 dl late port 15
        '{8'd2, 1'b1, 4'd7,  32'd60,   8'd59,  1'b1},  // R4 dl uses dl bounds
        '{8'd5, 1'b0, 4'd0,  32'd150,  8'hFF,  1'b0}   // R5 other type ignored
    };

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] t, input logic d, input logic [3:0] p,
                        input logic [31:0] dl, output logic err);
        @(negedge clk);
        msg_valid = 1'b1; msg_type = t; msg_dir = d; msg_port = p; msg_delay = dl;
        @(negedge clk);
        msg_valid = 1'b0;
        err = win_err;
    endtask

    task automatic read_lo(input int a, output logic [WW-1:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 7'(a); rd_hi = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic read_hi(output logic [WW-1:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_hi = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; rd_hi = 1'b0;
        v = rd_data;
    endtask

    task automatic read_full(input int a, output int v);
        logic [WW-1:0] lo, hi;
        read_lo(a, lo);
        read_hi(hi);
        v = int'({hi, lo});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int v;
        logic e;
        logic [WW-1:0] w;
        for (int i = 0; i < NC; i++) exp_cnt[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 win_err after reset", longint'(win_err), 0);
        read_full(0, v);  check("R1 total after reset", v, 0);
        read_full(99, v); check("R1 last counter after reset", v, 0);

        // vector walk: R2 R3 R4 R5 R10
        for (int k = 0; k < NV; k++) begin
            send(VEC[k].typ, VEC[k].dir, VEC[k].port, VEC[k].dly, e);
            check("R10 win_err pulse", longint'(e), longint'(VEC[k].err));
            if (VEC[k].typ == 8'd0 || VEC[k].typ == 8'd2) exp_cnt[0]++;
            if (VEC[k].idx != 8'hFF) exp_cnt[VEC[k].idx]++;
        end
        @(negedge clk);
        check("R10 pulse lasts one cycle", longint'(win_err), 0);

        // R6 R3 R4 R5: every slot holds its expected count
        for (int i = 0; i < NC; i++) begin
            read_full(i, v);
            check($sformatf("R6 R4 counter %0d", i), v, exp_cnt[i]);
        end

        // R7: window disabled
        win_en = 1'b0;
        send(8'd0, 1'b0, 4'd0, 32'd0, e);
        check("R7 no win_err when disabled", longint'(e), 0);
        read_full(1, v); check("R7 early count unchanged", v, exp_cnt[1]);
        exp_cnt[0]++;
        read_full(0, v); check("R7 R5 total still counts", v, exp_cnt[0]);
        win_en = 1'b1;

        // R8 R6: lower word wraps into upper; shadow stays coherent
        for (int k = 0; k < 20; k++) send(8'd0, 1'b0, 4'd0, 32'd150, e);
        exp_cnt[2] += 20; exp_cnt[0] += 20;
        read_lo(2, w);
        check("R6 low word after wrap", longint'(w), exp_cnt[2] % 16);
        for (int k = 0; k < 16; k++) send(8'd0, 1'b0, 4'd0, 32'd150, e);
        read_hi(w);
        check("R8 upper word from snapshot", longint'(w), (exp_cnt[2] / 16) % 16);
        exp_cnt[2] += 16; exp_cnt[0] += 16;
        read_full(2, v); check("R8 fresh full read", v, exp_cnt[2]);
        read_full(0, v); check("R5 total before clear", v, exp_cnt[0]);

        // R9: clear wins over simultaneous increment
        @(negedge clk);
        clr = 1'b1; msg_valid = 1'b1; msg_type = 8'd0; msg_delay = 32'd150;
        @(negedge clk);
        clr = 1'b0; msg_valid = 1'b0;
        read_full(0, v); check("R9 total cleared", v, 0);
        read_full(2, v); check("R9 class counter cleared", v, 0);
        read_full(75, v); check("R9 port counter cleared", v, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule